// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block turns a 32-bit IEEE-754 single-precision value into a fixed-point integer. The caller picks the target format per operation: signed or unsigned, and 16 or 32 bits wide. A 5-bit count of fraction bits scales the operand by a power of two before the conversion. The scaled value is always truncated toward zero. A value outside the range of the chosen format is clamped to that format's limit.

The result is always presented on a 32-bit bus. A 16-bit signed result is sign-extended and a 16-bit unsigned result is zero-extended. An invalid-operation flag goes with each result. It is raised exactly when the result had to be clamped, or when the operand is not a number. The datapath is a two-stage pipeline that accepts one operation per clock.

Top module: `floatFixConv`

## Requirements
- R1: `outValid` rises exactly two clock cycles after a cycle with `inValid` high and is low otherwise. One operation is accepted every cycle, and results come out in issue order.
- R2: The operand is multiplied by 2 to the power `fracBits` (0 to 31). The product is truncated toward zero, so 1.5 gives 1, -1.5 gives -1, 0.75 gives 0, and 2.75 with `fracBits`=2 gives 11.
- R3: When `inSigned`=1 and `inHalf`=1, values above 32767 give 0x00007FFF and values below -32768 give 0xFFFF8000. In-range negative results are sign-extended from bit 15.
- R4: When `inSigned`=1 and `inHalf`=0, values above 2147483647 give 0x7FFFFFFF and values below -2147483648 give 0x80000000.
- R5: When `inSigned`=0 and `inHalf`=1, values above 65535 give 0x0000FFFF. Bits 31:16 of the result are always zero.
- R6: When `inSigned`=0 and `inHalf`=0, values above 4294967295 give 0xFFFFFFFF. In-range values up to 0xFFFFFF00 are returned exactly.
- R7: In either unsigned format, any negative operand that is not zero or denormal gives result 0 with `outInvalid`=1. This holds even when its magnitude would truncate to 0. A negative zero gives 0 with no flag.
- R8: `outInvalid` is set exactly when clamping occurs. The bound values themselves are not flagged (32767, -32768, 65535, -2^31). A value beyond a bound only by a fraction, such as 32767.5 or -32768.5, is clamped and flagged.
- R9: A NaN operand (exponent field all ones, mantissa nonzero) gives result 0 with `outInvalid`=1, in every format.
- R10: Positive infinity gives the format maximum and negative infinity gives the format minimum. The minimum is 0 for unsigned formats. Both set `outInvalid`.
- R11: Zero and denormal operands (exponent field 0) give 0 with `outInvalid`=0, for any `fracBits`.
- R12: While `rstN` is low and after reset, `outValid`, `outResult` and `outInvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| inFloat | input | 32 | Single-precision operand |
| inSigned | input | 1 | 1 = signed target, 0 = unsigned |
| inHalf | input | 1 | 1 = 16-bit target, 0 = 32-bit |
| fracBits | input | 5 | Number of fraction bits (scale exponent) |
| outValid | output | 1 | Result strobe, two cycles after `inValid` |
| outResult | output | 32 | Converted value, extended to 32 bits |
| outInvalid | output | 1 | Invalid-operation flag for this result |

## Verification
The truncation cases use values with a fractional part of each sign, so they separate round-toward-zero from rounding to nearest and from rounding toward minus infinity. Each format is tried exactly at its bounds and just beyond them by a fraction. This shows whether the flag compares the untruncated value or the truncated one. Scaling is tried with `fracBits` of 2, 16 and 31, which moves in-range values past the signed 32-bit limit but not past the unsigned one. The special encodings (NaN, both infinities, negative zero, denormals) and a back-to-back stream of mixed formats check the ordering of the special-case decisions and that results stay in issue order.

// File: rtl/fixConvPkg.sv
package fixConvPkg;
  localparam int FLT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;

  typedef struct packed {
    logic loadIn;   // capture operands into stage 1
    logic loadOut;  // capture converted result into stage 2
  } fixConvStrobes_t;
endpackage

// File: rtl/fixConvCtrl.sv
module fixConvCtrl
  import fixConvPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output fixConvStrobes_t strobes,
  output logic            outValid
);
  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobes.loadIn  = inValid;
    strobes.loadOut = stage1Valid;
  end

  // R1
  latency_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);
  // R1
  latency_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid, 2) |-> !outValid);
endmodule

// File: rtl/fixConvPath.sv
module fixConvPath
  import fixConvPkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  fixConvStrobes_t   strobes,
  input  logic [FLT_W-1:0]  inFloat,
  input  logic              inSigned,
  input  logic              inHalf,
  input  logic [FRAC_W-1:0] fracBits,
  output logic [OUT_W-1:0]  resQ,
  output logic              invQ
);
  localparam int SIG_W   = MAN_W + 1;
  localparam int SHIFT_W = SIG_W + OUT_W;
  localparam int INT_W   = OUT_W + 1;
  localparam int SHA_W   = $clog2(OUT_W + 1);
  localparam int EE_W    = 10;

  localparam logic [INT_W-1:0] ONE_I     = INT_W'(1);
  localparam logic [INT_W-1:0] S_FULL_HI = (ONE_I << (OUT_W - 1)) - ONE_I;
  localparam logic [INT_W-1:0] S_HALF_HI = (ONE_I << (HALF_W - 1)) - ONE_I;
  localparam logic [INT_W-1:0] U_FULL_HI = (ONE_I << OUT_W) - ONE_I;
  localparam logic [INT_W-1:0] U_HALF_HI = (ONE_I << HALF_W) - ONE_I;
  localparam logic [INT_W-1:0] S_FULL_LO = ONE_I << (OUT_W - 1);
  localparam logic [INT_W-1:0] S_HALF_LO = ONE_I << (HALF_W - 1);

  // stage 1 operand registers
  logic [FLT_W-1:0]  fltQ;
  logic              sgnModeQ, halfModeQ;
  logic [FRAC_W-1:0] fracQ;
  // stage 2 mode copy (follows result)
  logic              sgnMode2Q, halfMode2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fltQ      <= '0;
      sgnModeQ  <= 1'b0;
      halfModeQ <= 1'b0;
      fracQ     <= '0;
    end else if (strobes.loadIn) begin
      fltQ      <= inFloat;
      sgnModeQ  <= inSigned;
      halfModeQ <= inHalf;
      fracQ     <= fracBits;
    end
  end

  logic                   negBit, isNan, isInf, isTiny, tooBig, fracNz, over;
  logic [EXP_W-1:0]       expF;
  logic [MAN_W-1:0]       manF;
  logic signed [EE_W-1:0] effExp;
  logic [SHIFT_W-1:0]     shifted;
  logic [INT_W-1:0]       intMag, hiLim, loLim;
  logic [OUT_W-1:0]       maxPat, minPat, plain, resD;
  logic                   invD;

  always_comb begin
    negBit = fltQ[FLT_W-1];
    expF   = fltQ[FLT_W-2 -: EXP_W];
    manF   = fltQ[MAN_W-1:0];
    isNan  = (&expF) && (|manF);
    isInf  = (&expF) && !(|manF);
    isTiny = (expF == '0);
    // scaling = adding the fraction count to the unbiased exponent
    effExp = $signed(EE_W'(expF)) - $signed(EE_W'(BIAS)) + $signed(EE_W'(fracQ));
    tooBig = (effExp > $signed(EE_W'(OUT_W)));
    if (effExp[EE_W-1] || tooBig) begin
      shifted = '0;
      intMag  = '0;
      fracNz  = 1'b1;
    end else begin
      shifted = SHIFT_W'({1'b1, manF}) << effExp[SHA_W-1:0];
      intMag  = shifted[SHIFT_W-1:MAN_W];
      fracNz  = |shifted[MAN_W-1:0];
    end

    hiLim  = sgnModeQ ? (halfModeQ ? S_HALF_HI : S_FULL_HI)
                      : (halfModeQ ? U_HALF_HI : U_FULL_HI);
    loLim  = halfModeQ ? S_HALF_LO : S_FULL_LO;
    maxPat = hiLim[OUT_W-1:0];
    minPat = halfModeQ ? {{(OUT_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}}
                       : {1'b1, {(OUT_W-1){1'b0}}};

    // compare on the untruncated value: equal integer part plus a fraction is beyond
    if (negBit) over = (intMag > loLim) || ((intMag == loLim) && fracNz);
    else        over = (intMag > hiLim) || ((intMag == hiLim) && fracNz);

    plain = negBit ? (~intMag[OUT_W-1:0] + 1'b1) : intMag[OUT_W-1:0];
    if (halfModeQ)
      plain = sgnModeQ ? {{(OUT_W-HALF_W){plain[HALF_W-1]}}, plain[HALF_W-1:0]}
                       : {{(OUT_W-HALF_W){1'b0}}, plain[HALF_W-1:0]};

    if (isNan) begin
      resD = '0;  invD = 1'b1;
    end else if (isTiny) begin
      resD = '0;  invD = 1'b0;
    end else if (negBit && !sgnModeQ) begin
      resD = '0;  invD = 1'b1;
    end else if (isInf || tooBig || over) begin
      resD = negBit ? minPat : maxPat;  invD = 1'b1;
    end else begin
      resD = plain;  invD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ       <= '0;
      invQ       <= 1'b0;
      sgnMode2Q  <= 1'b0;
      halfMode2Q <= 1'b0;
    end else if (strobes.loadOut) begin
      resQ       <= resD;
      invQ       <= invD;
      sgnMode2Q  <= sgnModeQ;
      halfMode2Q <= halfModeQ;
    end
  end

  // R9
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadOut && (&fltQ[30:23]) && (|fltQ[22:0])) |=> (resQ == '0 && invQ));
  // R11
  tiny_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadOut && fltQ[30:23] == '0) |=> (resQ == '0 && !invQ));
  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfMode2Q && !sgnMode2Q) |-> (resQ[OUT_W-1:HALF_W] == '0));
  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfMode2Q && sgnMode2Q) |-> (resQ[OUT_W-1:HALF_W] == {(OUT_W-HALF_W){resQ[HALF_W-1]}}));
  // R7
  uns_neg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadOut && !sgnModeQ && fltQ[31] && fltQ[30:23] != '0) |=> (resQ == '0 && invQ));
endmodule

// File: rtl/floatFixConv.sv
module floatFixConv
  import fixConvPkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       inFloat,
  input  logic              inSigned,
  input  logic              inHalf,
  input  logic [FRAC_W-1:0] fracBits,
  output logic              outValid,
  output logic [OUT_W-1:0]  outResult,
  output logic              outInvalid
);
  fixConvStrobes_t strobes;

  fixConvCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fixConvPath #(.OUT_W(OUT_W), .HALF_W(HALF_W), .FRAC_W(FRAC_W)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inFloat  (inFloat),
    .inSigned (inSigned),
    .inHalf   (inHalf),
    .fracBits (fracBits),
    .resQ     (outResult),
    .invQ     (outInvalid)
  );

  // R12
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outResult == '0 && !outInvalid));
endmodule

// File: tb/test_floatFixConv.sv
module test_floatFixConv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inFloat = '0;
  logic        inSigned = 1'b0;
  logic        inHalf = 1'b0;
  logic [4:0]  fracBits = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic        outInvalid;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  floatFixConv i_floatFixConv (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFloat(inFloat),
    .inSigned(inSigned), .inHalf(inHalf), .fracBits(fracBits),
    .outValid(outValid), .outResult(outResult), .outInvalid(outInvalid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] f, logic s, logic h, logic [4:0] fb);
    inValid = 1'b1; inFloat = f; inSigned = s; inHalf = h; fracBits = fb;
  endtask

  // one operation: drive, wait two edges, sample between edges
  task automatic convOne(string tag, logic [31:0] f, logic s, logic h, logic [4:0] fb,
                         logic [31:0] expR, logic expI);
    @(negedge clk); drive(f, s, h, fb);
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    check({tag, " valid"}, 32'(outValid), 32'd1);
    check({tag, " result"}, outResult, expR);
    check({tag, " flag"}, 32'(outInvalid), 32'(expI));
  endtask

  task automatic testReset();
    check("R12 valid", 32'(outValid), 32'd0);
    check("R12 result", outResult, 32'd0);
    check("R12 flag", 32'(outInvalid), 32'd0);
  endtask

  task automatic testTruncScale();
    convOne("R2 1.0", 32'h3F800000, 1, 0, 0, 32'd1, 0);
    convOne("R2 1.0x16", 32'h3F800000, 1, 0, 4, 32'd16, 0);
    convOne("R2 1.5", 32'h3FC00000, 1, 0, 0, 32'd1, 0);
    convOne("R2 -1.5", 32'hBFC00000, 1, 0, 0, 32'hFFFFFFFF, 0);
    convOne("R2 0.75", 32'h3F400000, 1, 0, 0, 32'd0, 0);
    convOne("R2 2.75x4", 32'h40300000, 1, 0, 2, 32'd11, 0);
  endtask

  task automatic testSigned16();
    convOne("R3 -1.5 half", 32'hBFC00000, 1, 1, 0, 32'hFFFFFFFF, 0);
    convOne("R8 32767", 32'h46FFFE00, 1, 1, 0, 32'h00007FFF, 0);
    convOne("R3 32767.5", 32'h46FFFF00, 1, 1, 0, 32'h00007FFF, 1);
    convOne("R3 32768", 32'h47000000, 1, 1, 0, 32'h00007FFF, 1);
    convOne("R8 -32768", 32'hC7000000, 1, 1, 0, 32'hFFFF8000, 0);
    convOne("R3 -32768.5", 32'hC7000080, 1, 1, 0, 32'hFFFF8000, 1);
    convOne("R3 1.0x65536", 32'h3F800000, 1, 1, 16, 32'h00007FFF, 1);
  endtask

  task automatic testSigned32();
    convOne("R4 2^31", 32'h4F000000, 1, 0, 0, 32'h7FFFFFFF, 1);
    convOne("R8 -2^31", 32'hCF000000, 1, 0, 0, 32'h80000000, 0);
    convOne("R4 1.0x2^31", 32'h3F800000, 1, 0, 31, 32'h7FFFFFFF, 1);
    convOne("R4 1e30", 32'h7149F2CA, 1, 0, 0, 32'h7FFFFFFF, 1);
    convOne("R4 -1e30", 32'hF149F2CA, 1, 0, 0, 32'h80000000, 1);
  endtask

  task automatic testUnsigned();
    convOne("R5 65535", 32'h477FFF00, 0, 1, 0, 32'h0000FFFF, 0);
    convOne("R5 65536", 32'h47800000, 0, 1, 0, 32'h0000FFFF, 1);
    convOne("R5 40000", 32'h471C4000, 0, 1, 0, 32'h00009C40, 0);
    convOne("R6 1.0x2^31", 32'h3F800000, 0, 0, 31, 32'h80000000, 0);
    convOne("R6 max exact", 32'h4F7FFFFF, 0, 0, 0, 32'hFFFFFF00, 0);
    convOne("R6 2^32", 32'h4F800000, 0, 0, 0, 32'hFFFFFFFF, 1);
    convOne("R7 -1.0", 32'hBF800000, 0, 0, 0, 32'd0, 1);
    convOne("R7 -0.5 half", 32'hBF000000, 0, 1, 0, 32'd0, 1);
    convOne("R7 -0.0", 32'h80000000, 0, 0, 0, 32'd0, 0);
  endtask

  task automatic testSpecials();
    convOne("R9 NaN s32", 32'h7FC00000, 1, 0, 0, 32'd0, 1);
    convOne("R9 NaN u16", 32'hFF800001, 0, 1, 5, 32'd0, 1);
    convOne("R10 +inf s32", 32'h7F800000, 1, 0, 0, 32'h7FFFFFFF, 1);
    convOne("R10 -inf s16", 32'hFF800000, 1, 1, 0, 32'hFFFF8000, 1);
    convOne("R10 +inf u16", 32'h7F800000, 0, 1, 0, 32'h0000FFFF, 1);
    convOne("R10 -inf u32", 32'hFF800000, 0, 0, 0, 32'd0, 1);
    convOne("R11 zero", 32'h00000000, 1, 0, 31, 32'd0, 0);
    convOne("R11 denormal", 32'h00000001, 1, 1, 31, 32'd0, 0);
    convOne("R11 -denormal u", 32'h807FFFFF, 0, 0, 31, 32'd0, 0);
  endtask

  task automatic testStream();
    @(negedge clk); drive(32'h40300000, 1, 0, 2);
    @(negedge clk); drive(32'hBFC00000, 1, 1, 0);
    @(negedge clk); drive(32'h47800000, 0, 1, 0);
    check("R1 stream A valid", 32'(outValid), 32'd1);
    check("R1 stream A", outResult, 32'd11);
    @(negedge clk); inValid = 1'b0;
    check("R1 stream B valid", 32'(outValid), 32'd1);
    check("R1 stream B", outResult, 32'hFFFFFFFF);
    @(negedge clk);
    check("R1 stream C", outResult, 32'h0000FFFF);
    check("R1 stream C flag", 32'(outInvalid), 32'd1);
    @(negedge clk);
    check("R1 idle valid", 32'(outValid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTruncScale();
    testSigned16();
    testSigned32();
    testUnsigned();
    testSpecials();
    testStream();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule